// File: doc/BRIEF.md
# Limit-Compare Interval Timer

A memory-mapped interval timer for a processor subsystem. A tick-enable input pulses at the counting rate (nominally 2 MHz, one pulse every 500 ns). A prescaler turns those pulses into counter advances. In system mode a counter climbs toward a programmed limit. When it gets there, the block raises a level interrupt and sets a sticky "reached" flag, and the count starts again from zero. Software services the interrupt by reading the limit register. That read returns the limit, drops the interrupt, clears the flag and restarts the count.

The count is left-justified in its register. The counter's value sits above a field of zero bits, and the top bit carries the reached flag. Two addresses load the limit. One also clears the count; the other changes only the limit. In user mode the same address window shows a wide free-running counter split across two words. Software can freeze and resume it through a run-control word. A static parameter can lock an instance in its reset mode, so that writes to the mode word are ignored.

Top module: `lct_timer`

## Requirements
- R1: After a synchronous active-high reset the limit reads 0x7FFFFFFF, the count and the reached flag read zero, `irq` is low, run control reads 1, and the mode word reads the `RESET_MODE` parameter.
- R2: In system mode each prescaler advance adds one to the count. The count word (offset 1) shows the count in bits 30..SHIFT (30..9 by default), and bits SHIFT-1..0 are always zero.
- R3: In system mode, when an advance would bring the count to or past limit bits 30..SHIFT, the count becomes zero, count-word bit 31 (reached) is set and `irq` goes high. Both stay set while later advances continue counting.
- R4: A write to offset 0 loads the limit and clears the count.
- R5: A write to offset 2 loads the limit and leaves the count as it was. If the count already lies at or beyond the new limit, the next advance wraps it and signals as in R3.
- R6: A written limit value of zero stores 0x7FFFFFFF. Any other value stores its bits 30..0.
- R7: In system mode a read at offset 0 (`rd_en` high) returns the limit in bits 30..0 with bit 31 zero. It also lowers `irq`, clears the reached flag, zeroes the count and restarts the prescaler phase.
- R8: In user mode offset 0 reads the upper 31 bits of the wide counter and offset 1 reads its lower bits in bits 30..SHIFT. Neither read has a side effect, and `irq` never rises.
- R9: Bit 0 written to offset 3 sets run control (1 run, 0 stop), and offset 3 reads it back. In user mode a stopped counter holds its value. In system mode run control has no effect.
- R10: Bit 0 written to offset 4 selects user mode (1) or system mode (0). A write that changes the mode clears the count. When `SYS_TIMER` is 1 the mode never changes.
- R11: The word offset is taken from `addr[4:2]`. Offsets 2, 5, 6 and 7 read zero. `rdata` follows `addr` whether or not `rd_en` is high.
- R12: A count-clearing access (offset 0 write, or an offset 0 read in system mode) in the same cycle as a tick leaves the count at zero, so that tick is not counted.
- R13: The counter advances once per `PRESC_DIV` tick pulses, on the last pulse of each group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle counting-rate pulse |
| rd_en | input | 1 | Read strobe; triggers read side effects |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Byte address within the window; bits 4..2 select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Level interrupt |

## Verification
Limit matching is tried in four ways: a steady run to a fixed limit, continued ticking after a hit to show that the flag and the interrupt are sticky, a limit raised without clearing the count, and a limit lowered below the running count. These separate a wrap taken on equality from one taken on overshoot. The two limit addresses are told apart by the count read back after each write. The acknowledging read is compared with a side-effect-free look at the same word, and with the same read in user mode. A second instance, set to a short low field and a divide-by-two prescaler, pushes the wide counter across its word boundary and shows that it advances only on every other pulse.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int REG_W = 32;

    localparam logic MODE_SYS  = 1'b0;
    localparam logic MODE_USER = 1'b1;

    localparam logic [2:0] OFS_LIM_CLR = 3'd0;
    localparam logic [2:0] OFS_COUNT   = 3'd1;
    localparam logic [2:0] OFS_LIM_KEEP = 3'd2;
    localparam logic [2:0] OFS_RUN     = 3'd3;
    localparam logic [2:0] OFS_MODE    = 3'd4;

    localparam logic [REG_W-2:0] LIM_MAX = '1;

    // Zero means "largest limit"; otherwise drop the top bit.
    function automatic logic [REG_W-2:0] fix_limit(input logic [REG_W-1:0] v);
        return (v == '0) ? LIM_MAX : v[REG_W-2:0];
    endfunction

endpackage

// File: rtl/lct_presc.sv
module lct_presc #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic clr,
    output logic adv
);

    generate
        if (DIV <= 1) begin : g_pass
            assign adv = tick_en & ~clr;
        end else begin : g_div
            localparam int PH_W = $clog2(DIV);
            localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

            logic [PH_W-1:0] ph_d, ph_q;

            always_comb begin
                ph_d = ph_q;
                if (clr) begin
                    ph_d = '0;
                end else if (tick_en) begin
                    ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) ph_q <= '0;
                else     ph_q <= ph_d;
            end

            assign adv = tick_en & ~clr & (ph_q == PH_LAST);
        end
    endgenerate

    // An advance is only ever produced by a tick pulse.
    p_adv_from_tick_r13: assert property (@(posedge clk) disable iff (rst)
        adv |-> tick_en);

endmodule

// File: rtl/lct_decode.sv
module lct_decode
    import lct_pkg::*;
#(
    parameter int SHIFT = 9,
    parameter int LO_W  = REG_W - 1 - SHIFT,
    parameter int CNT_W = LO_W + REG_W - 1
) (
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [4:0]       addr,
    input  logic             mode,
    input  logic [REG_W-2:0] lim,
    input  logic [CNT_W-1:0] cnt,
    input  logic             reached,
    input  logic             run,
    output logic             lim_wr,
    output logic             clr_cnt,
    output logic             ack,
    output logic             run_wr,
    output logic             mode_wr,
    output logic [REG_W-1:0] rdata
);

    logic [2:0] ofs;
    logic       unused_lsb;

    assign ofs        = addr[4:2];
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        lim_wr  = wr_en && (ofs == OFS_LIM_CLR || ofs == OFS_LIM_KEEP);
        ack     = rd_en && (ofs == OFS_LIM_CLR) && (mode == MODE_SYS);
        clr_cnt = (wr_en && ofs == OFS_LIM_CLR) || ack;
        run_wr  = wr_en && (ofs == OFS_RUN);
        mode_wr = wr_en && (ofs == OFS_MODE);
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_LIM_CLR: begin
                if (mode == MODE_SYS) rdata[REG_W-2:0] = lim;
                else                  rdata[REG_W-2:0] = cnt[CNT_W-1:LO_W];
            end
            OFS_COUNT: begin
                rdata[REG_W-1]       = reached;
                rdata[REG_W-2:SHIFT] = cnt[LO_W-1:0];
            end
            OFS_RUN:  rdata[0] = run;
            OFS_MODE: rdata[0] = mode;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/lct_core.sv
module lct_core
    import lct_pkg::*;
#(
    parameter int SHIFT      = 9,
    parameter int SYS_TIMER  = 0,
    parameter int RESET_MODE = 0,
    parameter int LO_W       = REG_W - 1 - SHIFT,
    parameter int CNT_W      = LO_W + REG_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             clr_cnt,
    input  logic             ack,
    input  logic             lim_wr,
    input  logic             run_wr,
    input  logic             mode_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-2:0] lim,
    output logic [CNT_W-1:0] cnt,
    output logic             reached,
    output logic             run,
    output logic             mode,
    output logic             irq
);

    typedef struct packed {
        logic [REG_W-2:0] lim;
        logic [CNT_W-1:0] cnt;
        logic             reached;
        logic             irq;
        logic             run;
        logic             mode;
    } state_t;

    localparam logic MODE_LOCKED = (SYS_TIMER != 0);
    localparam logic MODE_RST    = (RESET_MODE != 0);

    state_t          s_d, s_q;
    logic            mode_chg;
    logic [LO_W:0]   nxt_lo;
    logic [LO_W:0]   lim_ticks;

    assign lim_ticks = {1'b0, s_q.lim[REG_W-2:SHIFT]};
    assign nxt_lo    = {1'b0, s_q.cnt[LO_W-1:0]} + 1'b1;
    assign mode_chg  = mode_wr && !MODE_LOCKED && (wdata[0] != s_q.mode);

    always_comb begin
        s_d = s_q;
        if (lim_wr)                  s_d.lim  = fix_limit(wdata);
        if (run_wr)                  s_d.run  = wdata[0];
        if (mode_wr && !MODE_LOCKED) s_d.mode = wdata[0];

        if (clr_cnt || mode_chg) begin
            s_d.cnt = '0;
        end else if (adv) begin
            if (s_q.mode == MODE_SYS) begin
                if (nxt_lo >= lim_ticks) begin
                    s_d.cnt     = '0;
                    s_d.reached = 1'b1;
                    s_d.irq     = 1'b1;
                end else begin
                    s_d.cnt = CNT_W'(nxt_lo[LO_W-1:0]);
                end
            end else if (s_q.run) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        if (ack) begin
            s_d.reached = 1'b0;
            s_d.irq     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.lim     <= LIM_MAX;
            s_q.cnt     <= '0;
            s_q.reached <= 1'b0;
            s_q.irq     <= 1'b0;
            s_q.run     <= 1'b1;
            s_q.mode    <= MODE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign lim     = s_q.lim;
    assign cnt     = s_q.cnt;
    assign reached = s_q.reached;
    assign run     = s_q.run;
    assign mode    = s_q.mode;
    assign irq     = s_q.irq;

    // A rising interrupt comes with the flag set and a wrapped count.
    p_hit_wraps_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.irq) |-> (s_q.reached && s_q.cnt == '0));

    p_clear_count_r4: assert property (@(posedge clk) disable iff (rst)
        clr_cnt |=> (s_q.cnt == '0));

    p_ack_drops_r7: assert property (@(posedge clk) disable iff (rst)
        ack |=> (!s_q.irq && !s_q.reached));

    p_user_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (s_q.mode == MODE_USER) |=> !$rose(s_q.irq));

    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (s_q.mode == MODE_USER && !s_q.run && !clr_cnt && !mode_wr) |=> $stable(s_q.cnt));

    generate
        if (SYS_TIMER != 0) begin : g_locked_chk
            p_mode_locked_r10: assert property (@(posedge clk) disable iff (rst)
                mode_wr |=> $stable(s_q.mode));
        end
    endgenerate

endmodule

// File: rtl/lct_timer.sv
module lct_timer
    import lct_pkg::*;
#(
    parameter int SYS_TIMER  = 0,
    parameter int RESET_MODE = 0,
    parameter int SHIFT      = 9,
    parameter int PRESC_DIV  = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);

    localparam int LO_W  = REG_W - 1 - SHIFT;
    localparam int CNT_W = LO_W + REG_W - 1;

    logic             adv, clr_cnt, ack, lim_wr, run_wr, mode_wr;
    logic [REG_W-2:0] lim;
    logic [CNT_W-1:0] cnt;
    logic             reached, run, mode;

    lct_presc #(.DIV(PRESC_DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .clr     (clr_cnt),
        .adv     (adv)
    );

    lct_decode #(.SHIFT(SHIFT), .LO_W(LO_W), .CNT_W(CNT_W)) u_decode (
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .mode    (mode),
        .lim     (lim),
        .cnt     (cnt),
        .reached (reached),
        .run     (run),
        .lim_wr  (lim_wr),
        .clr_cnt (clr_cnt),
        .ack     (ack),
        .run_wr  (run_wr),
        .mode_wr (mode_wr),
        .rdata   (rdata)
    );

    lct_core #(
        .SHIFT      (SHIFT),
        .SYS_TIMER  (SYS_TIMER),
        .RESET_MODE (RESET_MODE),
        .LO_W       (LO_W),
        .CNT_W      (CNT_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .clr_cnt (clr_cnt),
        .ack     (ack),
        .lim_wr  (lim_wr),
        .run_wr  (run_wr),
        .mode_wr (mode_wr),
        .wdata   (wdata),
        .lim     (lim),
        .cnt     (cnt),
        .reached (reached),
        .run     (run),
        .mode    (mode),
        .irq     (irq)
    );

    // The zero field below the count never shows data.
    always_comb begin
        if (!rst && addr[4:2] == OFS_COUNT)
            a_low_zero_r2: assert (rdata[SHIFT-1:0] == '0);
    end

endmodule

// File: tb/lct_timer_tb.sv
module lct_timer_tb;

    localparam logic [1:0] K_W = 2'd0;  // write
    localparam logic [1:0] K_R = 2'd1;  // read with rd_en, check data
    localparam logic [1:0] K_P = 2'd2;  // look without rd_en, check data
    localparam logic [1:0] K_T = 2'd3;  // tick data times, check irq == exp[0]

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  ofs;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 57;
    localparam vec_t VEC [NV] = '{
        '{K_P, 3'd0, 32'h0, 32'h7FFFFFFF, 4'd1},  // R1 limit
        '{K_P, 3'd1, 32'h0, 32'h00000000, 4'd1},  // R1 count
        '{K_P, 3'd3, 32'h0, 32'h00000001, 4'd1},  // R1 run
        '{K_P, 3'd4, 32'h0, 32'h00000000, 4'd1},  // R1 mode
        '{K_T, 3'd0, 32'd0, 32'h0,        4'd1},  // R1 irq low
        '{K_W, 3'd0, 32'h00000A00, 32'h0, 4'd4},  // R4 limit ticks 5
        '{K_T, 3'd0, 32'd3, 32'h0,        4'd2},  // R2
        '{K_P, 3'd1, 32'h0, 32'h00000600, 4'd2},  // R2 count 3
        '{K_T, 3'd0, 32'd2, 32'h1,        4'd3},  // R3 hit
        '{K_P, 3'd1, 32'h0, 32'h80000000, 4'd3},  // R3 wrap + flag
        '{K_T, 3'd0, 32'd2, 32'h1,        4'd3},  // R3 sticky
        '{K_P, 3'd1, 32'h0, 32'h80000400, 4'd3},  // R3
        '{K_R, 3'd0, 32'h0, 32'h00000A00, 4'd7},  // R7 ack read
        '{K_T, 3'd0, 32'd0, 32'h0,        4'd7},  // R7 irq dropped
        '{K_P, 3'd1, 32'h0, 32'h00000000, 4'd7},  // R7 restart
        '{K_T, 3'd0, 32'd2, 32'h0,        4'd2},  // R2
        '{K_W, 3'd2, 32'h00000600, 32'h0, 4'd5},  // R5 limit ticks 3
        '{K_P, 3'd1, 32'h0, 32'h00000400, 4'd5},  // R5 count kept
        '{K_P, 3'd0, 32'h0, 32'h00000600, 4'd5},  // R5 limit loaded
        '{K_T, 3'd0, 32'd1, 32'h1,        4'd5},  // R5 hit at 3
        '{K_P, 3'd1, 32'h0, 32'h80000000, 4'd5},  // R5
        '{K_R, 3'd0, 32'h0, 32'h00000600, 4'd7},  // R7
        '{K_T, 3'd0, 32'd2, 32'h0,        4'd5},  // R5 count 2
        '{K_W, 3'd2, 32'h00000200, 32'h0, 4'd5},  // R5 limit ticks 1
        '{K_T, 3'd0, 32'd1, 32'h1,        4'd5},  // R5 overshoot wraps
        '{K_P, 3'd1, 32'h0, 32'h80000000, 4'd5},  // R5
        '{K_R, 3'd0, 32'h0, 32'h00000200, 4'd7},  // R7
        '{K_W, 3'd0, 32'h00000000, 32'h0, 4'd6},  // R6 zero
        '{K_P, 3'd0, 32'h0, 32'h7FFFFFFF, 4'd6},  // R6
        '{K_W, 3'd0, 32'hFFFFFA00, 32'h0, 4'd6},  // R6 top bit dropped
        '{K_P, 3'd0, 32'h0, 32'h7FFFFA00, 4'd6},  // R6
        '{K_W, 3'd3, 32'h0, 32'h0,        4'd9},  // R9 stop
        '{K_P, 3'd3, 32'h0, 32'h00000000, 4'd9},  // R9 read back
        '{K_T, 3'd0, 32'd2, 32'h0,        4'd9},  // R9
        '{K_P, 3'd1, 32'h0, 32'h00000400, 4'd9},  // R9 system ignores run
        '{K_W, 3'd4, 32'h1, 32'h0,        4'd10}, // R10 to user
        '{K_P, 3'd4, 32'h0, 32'h00000001, 4'd10}, // R10
        '{K_P, 3'd1, 32'h0, 32'h00000000, 4'd10}, // R10 cleared
        '{K_T, 3'd0, 32'd3, 32'h0,        4'd9},  // R9 stopped
        '{K_P, 3'd1, 32'h0, 32'h00000000, 4'd9},  // R9
        '{K_W, 3'd3, 32'h1, 32'h0,        4'd9},  // R9 start
        '{K_T, 3'd0, 32'd3, 32'h0,        4'd8},  // R8
        '{K_P, 3'd1, 32'h0, 32'h00000600, 4'd8},  // R8 low word
        '{K_P, 3'd0, 32'h0, 32'h00000000, 4'd8},  // R8 high word
        '{K_R, 3'd0, 32'h0, 32'h00000000, 4'd8},  // R8 read, no effect
        '{K_P, 3'd1, 32'h0, 32'h00000600, 4'd8},  // R8
        '{K_W, 3'd2, 32'h00000200, 32'h0, 4'd8},  // R8 small limit
        '{K_T, 3'd0, 32'd3, 32'h0,        4'd8},  // R8 no irq
        '{K_P, 3'd1, 32'h0, 32'h00000C00, 4'd8},  // R8
        '{K_P, 3'd2, 32'h0, 32'h00000000, 4'd11}, // R11
        '{K_P, 3'd5, 32'h0, 32'h00000000, 4'd11}, // R11
        '{K_P, 3'd6, 32'h0, 32'h00000000, 4'd11}, // R11
        '{K_P, 3'd7, 32'h0, 32'h00000000, 4'd11}, // R11
        '{K_W, 3'd3, 32'h0, 32'h0,        4'd9},  // R9 stop
        '{K_T, 3'd0, 32'd2, 32'h0,        4'd9},  // R9
        '{K_P, 3'd3, 32'h0, 32'h00000000, 4'd9},  // R9
        '{K_P, 3'd1, 32'h0, 32'h00000C00, 4'd9}   // R9 frozen
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_s;
    logic        irq, irq_s;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lct_timer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    lct_timer #(.SYS_TIMER(1), .RESET_MODE(1), .SHIFT(27), .PRESC_DIV(2)) u_dut_sys (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_s), .irq(irq_s)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] ofs, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = {ofs, 2'b00};
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] ofs, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = {ofs, 2'b00};
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] ofs, output logic [31:0] m, output logic [31:0] s);
        @(negedge clk);
        addr = {ofs, 2'b00};
        #1;
        m = rdata;
        s = rdata_s;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] vm, vs;
        string tag;
        do_reset();

        // Second instance: locked user-mode counter with short low field.
        peek(3'd4, vm, vs);
        chk("R1 locked instance mode", vs, 32'h1);
        chk("R1 locked instance irq", {31'b0, irq_s}, 32'h0);
        do_write(3'd4, 32'h0);
        peek(3'd4, vm, vs);
        chk("R10 mode write ignored", vs, 32'h1);
        do_ticks(33);
        peek(3'd0, vm, vs);
        chk("R8 high word carry", vs, 32'h1);
        peek(3'd1, vm, vs);
        chk("R13 odd pulse not counted", vs, 32'h0);
        do_ticks(1);
        peek(3'd1, vm, vs);
        chk("R13 even pulse counted", vs, 32'h08000000);

        // Vector table on the main instance.
        do_reset();
        for (int k = 0; k < NV; k++) begin
            tag = $sformatf("R%0d vec %0d", VEC[k].req, k);
            case (VEC[k].kind)
                K_W: do_write(VEC[k].ofs, VEC[k].data);
                K_R: begin
                    do_read(VEC[k].ofs, vm);
                    chk(tag, vm, VEC[k].exp);
                end
                K_P: begin
                    peek(VEC[k].ofs, vm, vs);
                    chk(tag, vm, VEC[k].exp);
                end
                default: begin
                    do_ticks(int'(VEC[k].data));
                    @(negedge clk);
                    chk(tag, {31'b0, irq}, VEC[k].exp);
                end
            endcase
        end

        // R12: clearing access and tick in the same cycle.
        do_reset();
        do_write(3'd0, 32'h00000A00);
        do_ticks(2);
        @(negedge clk);
        rd_en = 1'b1; addr = 5'd0; tick_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; tick_en = 1'b0;
        peek(3'd1, vm, vs);
        chk("R12 read beats tick", vm, 32'h0);
        do_ticks(1);
        peek(3'd1, vm, vs);
        chk("R12 counting resumes", vm, 32'h00000200);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'd0; wdata = 32'h00000A00; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        peek(3'd1, vm, vs);
        chk("R12 write beats tick", vm, 32'h0);

        // R11: byte-lane bits ignored in the decode.
        peek(3'd0, vm, vs);
        addr = 5'b00011;
        #1 chk("R11 low address bits ignored", rdata, 32'h00000A00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule